// File: doc/BRIEF.md
# Dual Limit Counter-Timer with Read-Acknowledged Interrupts

This block holds two tick-driven counter-timers behind one small register port. Timer 0 belongs to a single processor and drives the level-14 interrupt line. Timer 1 serves the whole system and drives the level-10 line. Each timer counts external ticks up to a programmed limit. When it reaches the limit it reloads and raises a level interrupt flag. The flag stays up until software reads that timer's limit register.

Each timer has three word registers. The first holds the limit. Writing it restarts the count, and reading it acknowledges the interrupt. The second returns the live count. The third is an alias of the limit that can be written without disturbing the count or the flag. A configuration word decides whether the per-processor timer counts at all. The register port is a plain single-cycle request port. Read data returns one cycle later with a one-cycle valid strobe. The port has no back-pressure: every request is accepted in the cycle it is presented. The tick input is a single-cycle enable that both timers share.

Top module: `lct_dual_timer`

## Requirements
- R1: After reset both interrupt lines are low, both counts read 1, both limits read 0 and the configuration word reads 1.
- R2: Each accepted tick whose count differs from the limit (or whose limit is 0) advances the count by one. The count register returns the current count, and writes to it are ignored.
- R3: A tick that arrives while the count equals a nonzero limit reloads the count to 1 and sets the timer's flag. The flag therefore repeats every `limit` ticks.
- R4: A set flag stays asserted until the limit register of that timer is read or written. Such a read returns the limit and clears the flag, unless a tick sets the flag in the same cycle, in which case the flag stays set.
- R5: Writing the limit register loads the limit from the low CNT_W data bits, sets the count to 1 and clears the flag. This write takes priority over a tick in the same cycle.
- R6: Writing the no-clear alias changes only the limit. Count and flag keep their values, and a tick in that cycle is compared against the old limit. Reading the alias returns the limit and leaves the flag alone.
- R7: With a limit of 0 the flag never sets. The count wraps from all ones to 1.
- R8: Configuration bit 0 set to 1 (its reset value) parks the per-processor timer so that it ignores ticks. Writing 0 puts it in timer mode. The system timer never parks.
- R9: Word addresses: 0 per-processor limit, 1 per-processor count, 2 per-processor alias, 4 system limit, 5 system count, 6 system alias, 8 configuration. All other addresses read 0 and ignore writes.
- R10: A read request (bus_sel high, bus_wr low) yields rd_valid high for exactly the following cycle, with rd_data carrying the zero-extended register value. rd_valid is low in every other cycle.
- R11: irq_lvl10 is the system timer's flag and irq_lvl14 is the per-processor timer's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle count enable shared by both timers |
| bus_sel | input | 1 | Register request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq_lvl10 | output | 1 | System timer interrupt, level |
| irq_lvl14 | output | 1 | Per-processor timer interrupt, level |

## Verification
A count that has drifted does not show on the interrupt lines until the next limit crossing, which can be up to a full period of `limit` ticks later. A count read exposes it within one cycle. The bench therefore reads the count register between ticks and compares both interrupt lines on every cycle. A wrong flag state shows on the interrupt pin in the cycle after the faulty edge. A wrongly stored limit that the no-clear alias hides shows as an interrupt at the wrong tick, and a limit read exposes it as soon as the limit is read back. The corner cases exercised are the acknowledge that collides with a reload, the restart that collides with a tick, a limit lowered beneath the running count (which forces the full wrap), and a zero limit.

// File: rtl/lct_pkg.sv
`timescale 1ns/1ps
package lct_pkg;
  localparam int ADDR_W  = 4;
  localparam int NTIMERS = 2;
  localparam int CPU_IDX = 0;
  localparam int SYS_IDX = 1;

  // word address = {bank, offset}
  localparam logic [1:0] OFS_LIMIT = 2'd0;
  localparam logic [1:0] OFS_COUNT = 2'd1;
  localparam logic [1:0] OFS_NOCLR = 2'd2;
  localparam logic [ADDR_W-3:0] BANK_CFG = 2'd2;

  localparam logic [ADDR_W-1:0] A_CPU_LIMIT = 4'd0;
  localparam logic [ADDR_W-1:0] A_SYS_LIMIT = 4'd4;
  localparam logic [ADDR_W-1:0] A_CFG       = 4'd8;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_LIMIT = 2'd1,
    RK_COUNT = 2'd2,
    RK_CFG   = 2'd3
  } rd_kind_t;

  typedef struct packed {
    logic wr_limit;
    logic wr_noclr;
    logic rd_limit;
  } tmr_ctl_t;
endpackage

// File: rtl/lct_decode.sv
`timescale 1ns/1ps
module lct_decode
  import lct_pkg::*;
#(
  parameter int NT  = NTIMERS,
  localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  output tmr_ctl_t [NT-1:0]     ctl,
  output logic                  cfg_wr,
  output rd_kind_t              rd_kind,
  output logic [IW-1:0]         rd_idx
);
  logic [ADDR_W-3:0] bank;
  logic [1:0]        ofs;
  logic              is_rd;
  logic              is_wr;

  assign bank  = bus_addr[ADDR_W-1:2];
  assign ofs   = bus_addr[1:0];
  assign is_rd = bus_sel && !bus_wr;
  assign is_wr = bus_sel && bus_wr;

  for (genvar t = 0; t < NT; t++) begin : g_ctl
    logic hit_bank;
    assign hit_bank        = (bank == (ADDR_W-2)'(t));
    assign ctl[t].wr_limit = is_wr && hit_bank && (ofs == OFS_LIMIT);
    assign ctl[t].wr_noclr = is_wr && hit_bank && (ofs == OFS_NOCLR);
    assign ctl[t].rd_limit = is_rd && hit_bank && (ofs == OFS_LIMIT);
  end

  assign cfg_wr = is_wr && (bank == BANK_CFG) && (ofs == 2'd0);

  always_comb begin
    rd_kind = RK_NONE;
    rd_idx  = IW'(bank);
    if (is_rd) begin
      if (bank == BANK_CFG) begin
        if (ofs == 2'd0) rd_kind = RK_CFG;
      end else if (int'(bank) < NT) begin
        case (ofs)
          OFS_LIMIT, OFS_NOCLR: rd_kind = RK_LIMIT;
          OFS_COUNT:            rd_kind = RK_COUNT;
          default:              rd_kind = RK_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lct_timer_core.sv
`timescale 1ns/1ps
module lct_timer_core #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             park,
  input  logic             wr_limit,
  input  logic             wr_noclr,
  input  logic             rd_limit,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] limit_o,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] TOP  = '1;

  logic [CNT_W-1:0] limit_q, count_q;
  logic             flag_q;
  logic             tick_en;
  logic             reach;
  logic [CNT_W-1:0] count_inc;

  assign tick_en   = tick && !park;
  assign reach     = tick_en && (limit_q != ZERO) && (count_q == limit_q);
  assign count_inc = (count_q == TOP) ? ONE : count_q + ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q <= ZERO;
      count_q <= ONE;
      flag_q  <= 1'b0;
    end else if (wr_limit) begin
      limit_q <= wdata;
      count_q <= ONE;
      flag_q  <= 1'b0;
    end else begin
      if (wr_noclr) limit_q <= wdata;
      if (tick_en)  count_q <= reach ? ONE : count_inc;
      if (reach)         flag_q <= 1'b1;
      else if (rd_limit) flag_q <= 1'b0;
    end
  end

  assign limit_o = limit_q;
  assign count_o = count_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/lct_readback.sv
`timescale 1ns/1ps
module lct_readback
  import lct_pkg::*;
#(
  parameter int NT     = NTIMERS,
  parameter int CNT_W  = 22,
  parameter int DATA_W = 32,
  localparam int IW    = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  rd_kind_t                   rd_kind,
  input  logic                       rd_req,
  input  logic [IW-1:0]              rd_idx,
  input  logic [NT-1:0][CNT_W-1:0]   limits,
  input  logic [NT-1:0][CNT_W-1:0]   counts,
  input  logic                       cfg_park,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data
);
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    case (rd_kind)
      RK_LIMIT: sel_data = DATA_W'(limits[rd_idx]);
      RK_COUNT: sel_data = DATA_W'(counts[rd_idx]);
      RK_CFG:   sel_data = DATA_W'(cfg_park);
      default:  sel_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? sel_data : '0;
    end
  end
endmodule

// File: rtl/lct_dual_timer.sv
`timescale 1ns/1ps
module lct_dual_timer
  import lct_pkg::*;
#(
  parameter int CNT_W  = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_lvl10,
  output logic              irq_lvl14
);
  localparam int NT = NTIMERS;
  localparam int IW = (NT > 1) ? $clog2(NT) : 1;

  tmr_ctl_t [NT-1:0]          ctl;
  logic                       cfg_wr;
  rd_kind_t                   rd_kind;
  logic [IW-1:0]              rd_idx;
  logic [NT-1:0][CNT_W-1:0]   lim_vec;
  logic [NT-1:0][CNT_W-1:0]   cnt_vec;
  logic [NT-1:0]              flag_vec;
  logic                       cfg_park;

  lct_decode #(.NT(NT)) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .ctl     (ctl),
    .cfg_wr  (cfg_wr),
    .rd_kind (rd_kind),
    .rd_idx  (rd_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_park <= 1'b1;
    else if (cfg_wr) cfg_park <= bus_wdata[0];
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic park_t;
    if (t == CPU_IDX) begin : g_cpu
      assign park_t = cfg_park;
    end else begin : g_sys
      assign park_t = 1'b0;
    end
    lct_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_i),
      .park    (park_t),
      .wr_limit(ctl[t].wr_limit),
      .wr_noclr(ctl[t].wr_noclr),
      .rd_limit(ctl[t].rd_limit),
      .wdata   (bus_wdata[CNT_W-1:0]),
      .limit_o (lim_vec[t]),
      .count_o (cnt_vec[t]),
      .flag_o  (flag_vec[t])
    );
  end

  if (CNT_W < DATA_W) begin : g_spare
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];
  end

  lct_readback #(.NT(NT), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_kind (rd_kind),
    .rd_req  (bus_sel && !bus_wr),
    .rd_idx  (rd_idx),
    .limits  (lim_vec),
    .counts  (cnt_vec),
    .cfg_park(cfg_park),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  assign irq_lvl10 = flag_vec[SYS_IDX];
  assign irq_lvl14 = flag_vec[CPU_IDX];
endmodule

// File: rtl/lct_dual_timer_chk.sv
`timescale 1ns/1ps
module lct_dual_timer_chk
  import lct_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rd_valid,
  input logic              irq_lvl10,
  input logic              irq_lvl14,
  input logic              cpu_park,
  input logic [CNT_W-1:0]  sys_limit
);
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl14 && !(bus_sel && bus_addr == A_CPU_LIMIT) |=> irq_lvl14);

  p_rd_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && bus_addr == A_SYS_LIMIT && !tick_i |=> !irq_lvl10);

  p_wr_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == A_SYS_LIMIT |=> !irq_lvl10);

  p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lvl10) |-> $past(tick_i));

  p_zero_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_limit == '0 && !irq_lvl10 |=> !irq_lvl10);

  p_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_park && !irq_lvl14 |=> !irq_lvl14);

  p_rd_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr |=> rd_valid);

  p_no_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !rd_valid);
endmodule

bind lct_dual_timer lct_dual_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_i   (tick_i),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .rd_valid (rd_valid),
  .irq_lvl10(irq_lvl10),
  .irq_lvl14(irq_lvl14),
  .cpu_park (cfg_park),
  .sys_limit(lim_vec[lct_pkg::SYS_IDX])
);

// File: tb/tb_lct_dual_timer.sv
`timescale 1ns/1ps
module tb_lct_dual_timer;
  localparam int CW = 8;
  localparam int CMASK = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq_lvl10, irq_lvl14;

  always #2.5 clk = ~clk;

  lct_dual_timer #(.CNT_W(CW), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_lvl10(irq_lvl10), .irq_lvl14(irq_lvl14)
  );

  // behavioural reference: index 0 per-processor, 1 system
  int    m_lim[2], m_cnt[2], m_flag[2];
  int    m_park, m_rdv, m_rdd;
  int    n_vec = 0, n_bad = 0;
  bit    done = 0;
  string cur_tag = "R1";

  task automatic model_reset();
    for (int t = 0; t < 2; t++) begin m_lim[t] = 0; m_cnt[t] = 1; m_flag[t] = 0; end
    m_park = 1; m_rdv = 0; m_rdd = 0;
  endtask

  task automatic model_edge(input bit s, input bit w, input int a, input int d, input bit tk);
    int bank, ofs;
    bank = a / 4; ofs = a % 4;
    m_rdv = (s && !w) ? 1 : 0;
    m_rdd = 0;
    if (s && !w) begin
      if (bank < 2 && (ofs == 0 || ofs == 2)) m_rdd = m_lim[bank];
      else if (bank < 2 && ofs == 1)          m_rdd = m_cnt[bank];
      else if (a == 8)                        m_rdd = m_park;
    end
    for (int t = 0; t < 2; t++) begin
      bit te, hit;
      te = tk && !(t == 0 && m_park == 1);
      if (s && w && a == t*4) begin
        m_lim[t] = d & CMASK; m_cnt[t] = 1; m_flag[t] = 0;
      end else begin
        hit = te && m_lim[t] != 0 && m_cnt[t] == m_lim[t];
        if (s && w && a == t*4 + 2) m_lim[t] = d & CMASK;
        if (te) m_cnt[t] = hit ? 1 : ((m_cnt[t] == CMASK) ? 1 : m_cnt[t] + 1);
        if (hit) m_flag[t] = 1;
        else if (s && !w && a == t*4) m_flag[t] = 0;
      end
    end
    if (s && w && a == 8) m_park = d & 1;
  endtask

  task automatic check(input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("irq_lvl10 (R11)", int'(irq_lvl10), m_flag[1]);
    check("irq_lvl14 (R11)", int'(irq_lvl14), m_flag[0]);
    check("rd_valid (R10)", int'(rd_valid), m_rdv);
    if (m_rdv == 1) check("rd_data", int'(rd_data), m_rdd);
  endtask

  task automatic step(input bit s, input bit w, input int a, input int d, input bit tk);
    bus_sel = s; bus_wr = w; bus_addr = 4'(a); bus_wdata = 32'(d); tick_i = tk;
    @(posedge clk);
    model_edge(s, w, a, d, tk);
    #1;
    compare_all();
    bus_sel = 0; bus_wr = 0; tick_i = 0;
  endtask

  task automatic wr(input int a, input int d, input bit tk = 0); step(1, 1, a, d, tk); endtask
  task automatic rd(input int a, input bit tk = 0);              step(1, 0, a, 0, tk); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset values seen at the port
    cur_tag = "R1";
    compare_all();
    rd(0); rd(1); rd(2); rd(4); rd(5); rd(6); rd(8);
    // R9: unmapped addresses
    cur_tag = "R9";
    rd(3); rd(7); rd(9); rd(15);
    wr(3, 77); wr(15, 5); wr(1, 99); wr(5, 42);
    rd(1); rd(5); rd(0); rd(4);
    // R8: parked per-processor timer ignores ticks, system timer counts
    cur_tag = "R8";
    ticks(5); rd(1); rd(5); rd(8);
    wr(8, 0); rd(8); ticks(2); rd(1);
    // R2 / R3: periodic operation, both timers
    cur_tag = "R3";
    wr(0, 3); wr(4, 5);
    for (int i = 0; i < 12; i++) begin ticks(1); rd(1); rd(5); end
    // R4: flag holds, limit read acknowledges
    cur_tag = "R4";
    ticks(3); rd(2); rd(6); rd(1);
    rd(0); rd(4);
    wr(0, 2); ticks(1); rd(0, 1); ticks(1); rd(0); rd(0);
    // R5: restart write against a tick in the same cycle
    cur_tag = "R5";
    wr(4, 4); ticks(3); wr(4, 6, 1); rd(5); ticks(5); rd(5); ticks(1); wr(4, 32'h1FF03);
    rd(4); ticks(3); rd(4);
    // R6: alias lowers limit below count; flag and count untouched
    cur_tag = "R6";
    wr(4, 50); ticks(10); wr(6, 4); rd(5); rd(4);
    ticks(250); rd(5); rd(4);
    wr(2, 9, 1); rd(1); rd(0);
    // R7: zero limit, full wrap and no interrupt
    cur_tag = "R7";
    wr(0, 0); ticks(260); rd(1);
    wr(6, 0); ticks(5); rd(5);
    // R2: plain counting reads
    cur_tag = "R2";
    wr(4, 200); for (int i = 0; i < 6; i++) begin ticks(1); rd(5); end
    // R8: re-park mid-run freezes the count
    cur_tag = "R8";
    wr(0, 3); ticks(1); wr(8, 1); ticks(4); rd(1); wr(8, 0); ticks(2); rd(1);
    cur_tag = "R10";
    rd(8); step(0, 0, 8, 0, 0); rd(2); rd(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog: actual hung expected finished", cur_tag);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule